// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a parameterized group of external interrupt lines and presents the single most urgent one to one processor. Each line has its own configuration word on a 32-bit register bus. The word sets whether the line is masked, whether it triggers on a level or on an edge, which level or edge counts as active, a 4-bit priority and an 8-bit vector. The processor holds a task-priority threshold, and only lines whose priority lies strictly above it are eligible.

Software reads the acknowledge register to learn which vector to service. That read puts the winning line in service. A write to the end-of-interrupt register retires it again. While a line is in service, its configuration word shows a read-only activity flag. A higher-priority line may interrupt the one in service. The in-service lines form a stack, so retirements unwind in the reverse of acknowledge order. An acknowledge that finds nothing eligible returns a programmable spurious vector and changes no state.

The register bus uses word addresses. Address 0 is the task priority (bits 3:0). Address 1 is the spurious vector (bits 7:0). Address 2 is the acknowledge register (read). Address 3 is end-of-interrupt (write). Addresses with the top address bit set select a line's configuration word, with the line number in the low address bits. Read data is combinational from the current state. A read with side effects takes effect on the clock edge that ends the read.

Top module: `irqc_top`

## Requirements
- R1: After reset every line is masked, and its configuration word reads 0x8000_0000. The task priority reads 15, the spurious vector reads 0xFF, no line is active and `irq_req_o` is low.
- R2: The configuration word places the vector in bits 7:0, the priority in 11:8, polarity in bit 16 (1 = high/rising, 0 = low/falling), sense in bit 17 (1 = level, 0 = edge), activity in bit 30 and mask in bit 31. Writes to bit 30 are ignored, and all other fields read back as written.
- R3: A masked line is never delivered, whatever its input does. Clearing the mask makes a pending line deliverable again, and the cleared mask reads back.
- R4: A level-sensed line is pending exactly while its input sits at the active level. Nothing is latched.
- R5: An edge-sensed line latches pending on the active edge: rising when polarity is 1, falling when it is 0. The latch is cleared by the acknowledge that takes that line, even if the input stays at its new level.
- R6: A line is eligible only if its priority is strictly greater than the task priority. A task priority of 15 blocks every line, including a line of priority 15. A task priority of 0 admits any priority from 1 upward.
- R7: Among eligible lines, the highest priority wins. On equal priority, the lowest-numbered line wins.
- R8: An acknowledge read returns the winner's vector in bits 7:0, with bits 31:8 zero. After the read, the winner's activity bit reads 1.
- R9: An acknowledge read with no eligible line returns the spurious vector register (bits 7:0) and changes no in-service or pending state.
- R10: While a line is in service, only lines with priority strictly above it are eligible. An end-of-interrupt retires the most recently acknowledged line first, and the threshold drops back to the next line in service.
- R11: A write of any value to end-of-interrupt clears the activity bit of the retired line. With nothing in service, the write has no effect.
- R12: `irq_req_o` is high exactly when at least one line is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src_i | input | NUM_SRC | External interrupt lines, synchronous to clk_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (needed for acknowledge side effects) |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_req_o | output | 1 | Interrupt request to the processor |

## Verification
Every cycle, the assertions check the following:
- A masked line is never acknowledged.
- The winner always beats both the task priority and the priority of the line in service.
- Each stack push raises the in-service priority, and the stack cannot overflow.
- An acknowledge marks the winner active.
- An empty acknowledge leaves the stack alone.
- An edge latch sets on its edge and clears on its acknowledge.

Only the bench scenarios can show the rest:
- the field layout and read-back of the configuration word;
- the tie-break toward the lowest line number;
- the unwinding order across nested retirements;
- the value of the spurious vector;
- the end-to-end timing from an input change to the request output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int unsigned PRIO_W = 4;
  parameter int unsigned VEC_W  = 8;

  // configuration word field positions
  parameter int unsigned F_PRIO_LSB = 8;
  parameter int unsigned F_POL      = 16;
  parameter int unsigned F_SENSE    = 17;
  parameter int unsigned F_ACT      = 30;
  parameter int unsigned F_MASK     = 31;

  // global register word addresses
  parameter int unsigned A_TPR  = 0;
  parameter int unsigned A_SPUR = 1;
  parameter int unsigned A_ACK  = 2;
  parameter int unsigned A_EOI  = 3;

  typedef struct packed {
    logic              mask;
    logic              sense;
    logic              pol;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;
endpackage

// File: rtl/irqc_src_gate.sv
module irqc_src_gate
  import irqc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cfg_we_i,
  input  src_cfg_t cfg_wval_i,
  input  logic     ack_clr_i,
  input  logic     irq_i,
  output src_cfg_t cfg_o,
  output logic     pending_o
);
  src_cfg_t cfg_q;
  logic     prev_q, edge_q, edge_d, act_edge;

  always_comb begin
    act_edge = cfg_q.pol ? (irq_i & ~prev_q) : (~irq_i & prev_q);
    edge_d   = edge_q;
    if (cfg_q.sense) begin
      edge_d = 1'b0;
    end else begin
      if (ack_clr_i) edge_d = 1'b0;
      if (act_edge)  edge_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '{mask: 1'b1, default: '0};
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wval_i;
      prev_q <= irq_i;
      edge_q <= edge_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign pending_o = cfg_q.sense ? (irq_i == cfg_q.pol) : edge_q;

  // R5: an active edge on an edge-sensed line is latched
  a_r5_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.sense && act_edge) |=> edge_q);
  // R5: acknowledge without a new edge clears the latch
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.sense && ack_clr_i && !act_edge) |=> !edge_q);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  src_cfg_t           cfg_i [NUM_SRC],
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic [PRIO_W-1:0]  tpr_i,
  input  logic [PRIO_W-1:0]  svc_prio_i,
  output logic               win_valid_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [PRIO_W-1:0]  win_prio_o,
  output logic [VEC_W-1:0]   win_vec_o
);
  logic [PRIO_W-1:0]  floor_prio;
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    floor_prio = (tpr_i > svc_prio_i) ? tpr_i : svc_prio_i;
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = pending_i[i] & ~cfg_i[i].mask & (cfg_i[i].prio > floor_prio);
    end
  end

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_prio_o  = '0;
    win_vec_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid_o || cfg_i[i].prio > win_prio_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_prio_o  = cfg_i[i].prio;
        win_vec_o   = cfg_i[i].vec;
      end
    end
  end
endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned DEPTH  = (1 << PRIO_W) - 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [IDX_W-1:0]   push_idx_i,
  input  logic [PRIO_W-1:0]  push_prio_i,
  input  logic               pop_i,
  output logic [PRIO_W-1:0]  top_prio_o,
  output logic [NUM_SRC-1:0] active_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [IDX_W-1:0]  idx_q  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              full, empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (push_i && !full) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (pop_i && !empty) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic slot_we;
    assign slot_we = push_i && !full && (cnt_q == CNT_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q[k]  <= '0;
        prio_q[k] <= '0;
      end else if (slot_we) begin
        idx_q[k]  <= push_idx_i;
        prio_q[k] <= push_prio_i;
      end
    end
  end

  always_comb begin
    top_prio_o = '0;
    active_o   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (CNT_W'(k) < cnt_q)      active_o[idx_q[k]] = 1'b1;
      if (CNT_W'(k + 1) == cnt_q) top_prio_o = prio_q[k];
    end
  end

  assign count_o = cnt_q;

  // R10: a nested acknowledge always outranks the line it preempts
  a_r10_push_outranks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty) |-> (push_prio_i > top_prio_o));
  // R10: strictly rising priorities can never overflow the stack
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full);
  // R11: end-of-interrupt retires exactly one entry
  a_r11_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R11: end-of-interrupt on an empty stack does nothing
  a_r11_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> (cnt_q == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned SEL_W  = ADDR_W - 1,
  localparam int unsigned CNT_W  = $clog2((1 << PRIO_W))
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_req_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // bus decode
  logic               src_hit, ack_fire, eoi_fire, tpr_we, spur_we;
  logic [SEL_W-1:0]   src_sel;
  logic [NUM_SRC-1:0] cfg_we;
  src_cfg_t           cfg_wval;
  logic               wdata_unused;

  assign src_hit  = reg_addr_i[ADDR_W-1];
  assign src_sel  = reg_addr_i[SEL_W-1:0];
  assign ack_fire = reg_rd_i && !src_hit && (reg_addr_i == ADDR_W'(A_ACK));
  assign eoi_fire = reg_wr_i && !src_hit && (reg_addr_i == ADDR_W'(A_EOI));
  assign tpr_we   = reg_wr_i && !src_hit && (reg_addr_i == ADDR_W'(A_TPR));
  assign spur_we  = reg_wr_i && !src_hit && (reg_addr_i == ADDR_W'(A_SPUR));

  always_comb begin
    cfg_wval.mask  = reg_wdata_i[F_MASK];
    cfg_wval.sense = reg_wdata_i[F_SENSE];
    cfg_wval.pol   = reg_wdata_i[F_POL];
    cfg_wval.prio  = reg_wdata_i[F_PRIO_LSB +: PRIO_W];
    cfg_wval.vec   = reg_wdata_i[VEC_W-1:0];
  end
  assign wdata_unused = ^{reg_wdata_i[30:18], reg_wdata_i[15:12]};

  // global registers
  logic [PRIO_W-1:0] tpr_q;
  logic [VEC_W-1:0]  spur_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q  <= '1;
      spur_q <= '1;
    end else begin
      if (tpr_we)  tpr_q  <= reg_wdata_i[PRIO_W-1:0];
      if (spur_we) spur_q <= reg_wdata_i[VEC_W-1:0];
    end
  end

  // per-line capture
  src_cfg_t           cfg [NUM_SRC];
  logic [NUM_SRC-1:0] pending, ack_clr, mask_vec;
  logic               win_valid, push;
  logic [IDX_W-1:0]   win_idx;
  logic [PRIO_W-1:0]  win_prio, svc_prio;
  logic [VEC_W-1:0]   win_vec;
  logic [NUM_SRC-1:0] active;
  logic [CNT_W-1:0]   svc_cnt;

  assign push = ack_fire && win_valid;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign cfg_we[i]   = reg_wr_i && src_hit && (src_sel == SEL_W'(i));
    assign ack_clr[i]  = push && (win_idx == IDX_W'(i));
    assign mask_vec[i] = cfg[i].mask;
    irqc_src_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .cfg_we_i   (cfg_we[i]),
      .cfg_wval_i (cfg_wval),
      .ack_clr_i  (ack_clr[i]),
      .irq_i      (irq_src_i[i]),
      .cfg_o      (cfg[i]),
      .pending_o  (pending[i])
    );
  end

  irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .cfg_i       (cfg),
    .pending_i   (pending),
    .tpr_i       (tpr_q),
    .svc_prio_i  (svc_prio),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_prio_o  (win_prio),
    .win_vec_o   (win_vec)
  );

  irqc_svc_stack #(.NUM_SRC(NUM_SRC)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .push_i      (push),
    .push_idx_i  (win_idx),
    .push_prio_i (win_prio),
    .pop_i       (eoi_fire),
    .top_prio_o  (svc_prio),
    .active_o    (active),
    .count_o     (svc_cnt)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (src_hit) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (src_sel == SEL_W'(i)) begin
          reg_rdata_o[F_MASK]                   = cfg[i].mask;
          reg_rdata_o[F_ACT]                    = active[i];
          reg_rdata_o[F_SENSE]                  = cfg[i].sense;
          reg_rdata_o[F_POL]                    = cfg[i].pol;
          reg_rdata_o[F_PRIO_LSB +: PRIO_W]     = cfg[i].prio;
          reg_rdata_o[VEC_W-1:0]                = cfg[i].vec;
        end
      end
    end else begin
      case (reg_addr_i)
        ADDR_W'(A_TPR):  reg_rdata_o[PRIO_W-1:0] = tpr_q;
        ADDR_W'(A_SPUR): reg_rdata_o[VEC_W-1:0]  = spur_q;
        ADDR_W'(A_ACK):  reg_rdata_o[VEC_W-1:0]  = win_valid ? win_vec : spur_q;
        default:         reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_req_o = win_valid;

  // R3: a masked line is never taken by an acknowledge
  a_r3_masked_not_taken: assert property (@(posedge clk_i) disable iff (!rst_n)
    push |-> !mask_vec[win_idx]);
  // R6: the winner lies above the task priority
  a_r6_above_task: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_valid |-> (win_prio > tpr_q));
  // R10: the winner lies above the line in service
  a_r10_above_service: assert property (@(posedge clk_i) disable iff (!rst_n)
    win_valid |-> (win_prio > svc_prio));
  // R8: an acknowledged line shows active afterwards
  a_r8_ack_marks_active: assert property (@(posedge clk_i) disable iff (!rst_n)
    push |=> active[$past(win_idx)]);
  // R9: an empty acknowledge leaves the in-service stack alone
  a_r9_spurious_no_change: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_fire && !win_valid) |=> $stable(svc_cnt));
  // R12: a request needs an unmasked pending line
  a_r12_req_has_source: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_req_o |-> |(pending & ~mask_vec));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int NUM_SRC = 8;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] TPR = 0, SPUR = 1, ACK = 2, EOI = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_SRC-1:0] irq_src;
  logic               wr, rd;
  logic [ADDR_W-1:0]  addr;
  logic [31:0]        wdata, rdata;
  logic               irq_req;

  always #10 clk = ~clk;

  irqc_top #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(irq_src),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_req_o(irq_req)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t exp_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  function automatic logic [ADDR_W-1:0] src_a(int i);
    return ADDR_W'(8 + i);
  endfunction

  // driver tasks
  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr = 1'b0;
  endtask

  task automatic rd_chk(logic [ADDR_W-1:0] a, logic [31:0] e, string req);
    item_t it;
    @(negedge clk);
    rd = 1'b1; addr = a;
    it.is_irq = 1'b0; it.exp = e; it.req = req;
    exp_q.push_back(it);
    @(posedge clk); #2;
    rd = 1'b0;
  endtask

  task automatic irq_chk(logic e, string req);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic set_src(int i, logic v);
    @(negedge clk);
    irq_src[i] = v;
  endtask

  // monitor: compares queued expectations shortly before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = exp_q.pop_front();
        act = it.is_irq ? {31'b0, irq_req} : rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_src = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(TPR, 32'h0000_000F, "R1 task priority");
    rd_chk(SPUR, 32'h0000_00FF, "R1 spurious");
    rd_chk(src_a(0), 32'h8000_0000, "R1 line masked");
    irq_chk(1'b0, "R1 no request");
    rd_chk(ACK, 32'h0000_00FF, "R1 ack spurious");

    // R2 field layout; activity bit written 1 is ignored
    bus_wr(src_a(1), 32'h4003_05A1);
    rd_chk(src_a(1), 32'h0003_05A1, "R2 readback");

    // R4 level, R12 request
    bus_wr(TPR, 32'h0);
    set_src(1, 1'b1);
    irq_chk(1'b1, "R4 level active R12");
    set_src(1, 1'b0);
    irq_chk(1'b0, "R4 level not latched");

    // R3 masking
    bus_wr(src_a(1), 32'h8003_05A1);
    set_src(1, 1'b1);
    irq_chk(1'b0, "R3 masked no request");
    rd_chk(ACK, 32'h0000_00FF, "R3 masked gives spurious");
    rd_chk(src_a(1), 32'h8003_05A1, "R3 mask readback");
    bus_wr(src_a(1), 32'h0003_05A1);
    rd_chk(src_a(1), 32'h0003_05A1, "R3 unmask readback");
    irq_chk(1'b1, "R3 unmasked request");

    // R6 threshold
    bus_wr(TPR, 32'h5);
    irq_chk(1'b0, "R6 equal priority blocked");
    bus_wr(TPR, 32'h4);
    irq_chk(1'b1, "R6 above threshold");
    bus_wr(TPR, 32'h0);

    // R8 acknowledge, R10 same priority held off, R11 retire
    rd_chk(ACK, 32'h0000_00A1, "R8 ack vector");
    rd_chk(src_a(1), 32'h4003_05A1, "R8 activity set");
    irq_chk(1'b0, "R10 same priority held off");
    bus_wr(EOI, 32'h0000_1234);
    rd_chk(src_a(1), 32'h0003_05A1, "R11 activity cleared");
    irq_chk(1'b1, "R11 level reasserts");
    set_src(1, 1'b0);

    // R5 rising edge
    bus_wr(src_a(2), 32'h0001_0322);
    set_src(2, 1'b1);
    irq_chk(1'b1, "R5 rising latched");
    rd_chk(ACK, 32'h0000_0022, "R5 ack edge line");
    irq_chk(1'b0, "R5 ack clears latch");
    bus_wr(EOI, 32'h0);
    irq_chk(1'b0, "R5 no relatch on held level");
    set_src(2, 1'b0);

    // R5 falling edge
    bus_wr(src_a(3), 32'h0000_0333);
    set_src(3, 1'b1);
    irq_chk(1'b0, "R5 rise ignored for falling");
    set_src(3, 1'b0);
    irq_chk(1'b1, "R5 falling latched");
    rd_chk(ACK, 32'h0000_0033, "R5 ack falling line");
    bus_wr(EOI, 32'h0);
    irq_chk(1'b0, "R5 falling retired");

    // R7 tie break, R10 nesting
    bus_wr(src_a(4), 32'h0003_0744);
    bus_wr(src_a(5), 32'h0003_0755);
    bus_wr(src_a(6), 32'h0003_0966);
    set_src(4, 1'b1);
    set_src(5, 1'b1);
    rd_chk(ACK, 32'h0000_0044, "R7 tie lowest index");
    irq_chk(1'b0, "R10 equal priority blocked");
    set_src(6, 1'b1);
    irq_chk(1'b1, "R10 higher preempts");
    rd_chk(ACK, 32'h0000_0066, "R7 highest priority");
    set_src(6, 1'b0);
    rd_chk(src_a(6), 32'h4003_0966, "R10 nested active");
    bus_wr(EOI, 32'h0);
    rd_chk(src_a(6), 32'h0003_0966, "R10 newest retired first");
    rd_chk(src_a(4), 32'h4003_0744, "R10 outer still active");
    irq_chk(1'b0, "R10 threshold back to outer");
    bus_wr(EOI, 32'h0);
    irq_chk(1'b1, "R10 all retired");
    rd_chk(ACK, 32'h0000_0044, "R7 tie again");
    bus_wr(EOI, 32'h0);
    set_src(4, 1'b0);
    set_src(5, 1'b0);
    irq_chk(1'b0, "R12 idle");

    // R11 empty retire, R9 spurious
    bus_wr(EOI, 32'hFFFF_FFFF);
    rd_chk(src_a(4), 32'h0003_0744, "R11 empty retire no effect");
    bus_wr(SPUR, 32'h0000_003C);
    rd_chk(SPUR, 32'h0000_003C, "R9 spurious readback");
    rd_chk(ACK, 32'h0000_003C, "R9 programmed spurious");
    rd_chk(src_a(4), 32'h0003_0744, "R9 no state change");

    // R6 threshold 15 blocks priority 15
    bus_wr(src_a(7), 32'h0003_0F77);
    bus_wr(TPR, 32'hF);
    set_src(7, 1'b1);
    set_src(6, 1'b1);
    irq_chk(1'b0, "R6 fifteen blocks all");
    rd_chk(ACK, 32'h0000_003C, "R6 blocked gives spurious");
    bus_wr(TPR, 32'hE);
    irq_chk(1'b1, "R6 fourteen admits fifteen");
    rd_chk(ACK, 32'h0000_0077, "R6 top priority taken");
    bus_wr(EOI, 32'h0);
    set_src(7, 1'b0);
    set_src(6, 1'b0);
    irq_chk(1'b0, "R12 final idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule